// File: doc/BRIEF.md
# Boot ROM Overlay Memory Mapper

This block sits between a processor data bus and the audio work RAM behind it. It also holds a 64-byte boot ROM that can be laid over the top 64 bytes of the address space. For each read it picks one of three sources: the boot ROM, the RAM, or a fixed fill byte. For each write it decides whether the RAM is updated. Three control bits come from a separate register block. Overlay enable maps the ROM over the top window. Memory off blanks the RAM. Write permit allows stores.

Reads are synchronous and have one cycle of latency. The source choice is made from the address and control bits in the request cycle. It is registered so that it reaches the output together with the data. Writes always target the RAM, including writes into the overlaid window and into the 0xF0–0xFF range that the register block also decodes. A program can therefore fill the RAM under the boot ROM while it still executes from the ROM. The address width is a parameter: 16 bits gives the full 64 KiB part, and the default is kept small for elaboration.

Top module: `bootovl_memmap`

## Requirements
- R1: A read request (`rd_en`=1) sampled at a clock edge gives `rvalid`=1 with `rdata` valid after that edge, for exactly one cycle. With no request, `rvalid` is 0 and `rdata` holds its last value.
- R2: When `rom_en`=1 and the address lies in the top 64 locations (all address bits above bit 5 are 1), the read returns ROM byte `i = addr[5:0]`, where byte i = ((i*29) mod 256) XOR 0xA5. The ROM takes priority over `ram_off`.
- R3: When `ram_off`=1 and R2 does not apply, a read returns 0x5A.
- R4: Otherwise a read returns the byte last written to that RAM address.
- R5: A write (`wr_en`=1) updates the RAM only when `ram_wr_ok`=1 and `ram_off`=0. In every other case the stored byte is left unchanged.
- R6: A write into the top 64-byte window updates the RAM whatever the value of `rom_en`. With `rom_en`=0 the written byte reads back.
- R7: Addresses 0xF0–0xFF are stored and read like any other RAM location, under the same write gating.
- R8: A read and a write to the same address in the same cycle return the byte stored before the write. The write still takes effect.
- R9: After reset, `rvalid`=0 and `rdata`=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | Byte address for read and write |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| rom_en | input | 1 | Overlay the boot ROM on the top 64 bytes |
| ram_off | input | 1 | Blank the RAM: reads give the fill byte, writes are dropped |
| ram_wr_ok | input | 1 | Permit RAM writes |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | Read data valid, one cycle after the request |

## Verification
The assertions check on every cycle that `rvalid` follows a request by exactly one cycle and that `rdata` holds between reads. They also check that overlay reads return the computed ROM byte, that blanked reads return 0x5A, and that the RAM write strobe never fires unless the write is permitted. Whether the RAM actually holds what was written can only be shown by the bench. This covers writes under the overlay, writes to the register range, dropped writes and read-first collisions. The bench shows this through full-address write/read sweeps and a long pseudo-random run with varying control bits, checked against its own array model.

// File: rtl/bootovl_pkg.sv
package bootovl_pkg;

  typedef enum logic [1:0] {
    SRC_RAM  = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_FILL = 2'd2
  } src_e;

  localparam int ROM_IDX_W = 6;
  localparam int ROM_DEPTH = 1 << ROM_IDX_W;
  localparam logic [7:0] FILL_BYTE = 8'h5A;

  // Boot ROM contents: index scaled by 29, folded with 0xA5
  function automatic logic [7:0] rom_byte(input logic [ROM_IDX_W-1:0] idx);
    logic [7:0] scaled;
    scaled = {2'b00, idx} * 8'd29;
    return scaled ^ 8'hA5;
  endfunction

endpackage

// File: rtl/bootovl_decode.sv
module bootovl_decode
  import bootovl_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          rom_en,
  input  logic          ram_off,
  input  logic          ram_wr_ok,
  output logic          rom_hit,
  output src_e          rd_src,
  output logic          ram_re,
  output logic          ram_we
);

  localparam int HI_W = AW - ROM_IDX_W;

  logic in_window;
  assign in_window = &addr[AW-1 -: HI_W];
  assign rom_hit   = rom_en & in_window;

  always_comb begin
    if (rom_hit)      rd_src = SRC_ROM;
    else if (ram_off) rd_src = SRC_FILL;
    else              rd_src = SRC_RAM;
  end

  assign ram_re = rd_en & (rd_src == SRC_RAM);
  // writes ignore the overlay entirely
  assign ram_we = wr_en & ram_wr_ok & ~ram_off;

endmodule

// File: rtl/bootovl_ram.sv
module bootovl_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic          we,
  output logic [7:0]    q
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // read-first: q takes the pre-write contents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 8'h00;
    else if (re) q <= mem[addr];
  end

endmodule

// File: rtl/bootovl_rom.sv
module bootovl_rom
  import bootovl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROM_IDX_W-1:0] idx,
  input  logic                 re,
  output logic [7:0]           q
);

  logic [7:0] table_w [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_rom
    assign table_w[i] = rom_byte(ROM_IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 8'h00;
    else if (re) q <= table_w[idx];
  end

endmodule

// File: rtl/bootovl_memmap.sv
module bootovl_memmap
  import bootovl_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic          rom_en,
  input  logic          ram_off,
  input  logic          ram_wr_ok,
  output logic [7:0]    rdata,
  output logic          rvalid
);

  logic       rom_hit;
  src_e       rd_src;
  logic       ram_re;
  logic       ram_we;
  logic       rom_re;
  logic [7:0] ram_q;
  logic [7:0] rom_q;
  src_e       src_q;

  bootovl_decode #(.AW(AW)) u_decode (
    .addr      (addr),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rom_en    (rom_en),
    .ram_off   (ram_off),
    .ram_wr_ok (ram_wr_ok),
    .rom_hit   (rom_hit),
    .rd_src    (rd_src),
    .ram_re    (ram_re),
    .ram_we    (ram_we)
  );

  bootovl_ram #(.AW(AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .re    (ram_re),
    .we    (ram_we),
    .q     (ram_q)
  );

  assign rom_re = rd_en & rom_hit;

  bootovl_rom u_rom (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (addr[ROM_IDX_W-1:0]),
    .re    (rom_re),
    .q     (rom_q)
  );

  // source select registered to line up with the synchronous data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_RAM;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) src_q <= rd_src;
    end
  end

  always_comb begin
    case (src_q)
      SRC_ROM:  rdata = rom_q;
      SRC_FILL: rdata = FILL_BYTE;
      default:  rdata = ram_q;
    endcase
  end

endmodule

// File: rtl/bootovl_chk.sv
module bootovl_chk
  import bootovl_pkg::*;
#(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          rd_en,
  input logic          wr_en,
  input logic          rom_en,
  input logic          ram_off,
  input logic          ram_wr_ok,
  input logic [7:0]    rdata,
  input logic          rvalid,
  input logic          rom_hit,
  input logic          ram_we
);

  // R1
  rvalid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  // R1
  rvalid_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R2
  rom_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rom_en && (&addr[AW-1:ROM_IDX_W]))
      |=> rdata == rom_byte($past(addr[ROM_IDX_W-1:0])));

  // R3
  fill_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ram_off && !rom_hit) |=> rdata == 8'h5A);

  // R5
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr_en && ram_wr_ok && !ram_off));

endmodule

bind bootovl_memmap bootovl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .rom_en    (rom_en),
  .ram_off   (ram_off),
  .ram_wr_ok (ram_wr_ok),
  .rdata     (rdata),
  .rvalid    (rvalid),
  .rom_hit   (rom_hit),
  .ram_we    (ram_we)
);

// File: tb/test_bootovl_memmap.sv
`timescale 1ns/1ps
module test_bootovl_memmap;

  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int TOP   = DEPTH - 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          rd_en = 1'b0, wr_en = 1'b0;
  logic          rom_en = 1'b1, ram_off = 1'b0, ram_wr_ok = 1'b1;
  logic [7:0]    rdata;
  logic          rvalid;

  int checks = 0;
  int errors = 0;
  logic [7:0]  model [DEPTH];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2.5 clk = ~clk;

  bootovl_memmap #(.AW(AW)) i_bootovl_memmap (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .rom_en(rom_en), .ram_off(ram_off),
    .ram_wr_ok(ram_wr_ok), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [7:0] boot_byte(input int a);
    int i;
    i = a % 64;
    return 8'((i * 29) % 256) ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus cycle: drive after negedge, check at the following negedge
  task automatic op(input string req, input bit rd, input bit wr, input int a,
                    input logic [7:0] d, input bit ren, input bit off, input bit wok);
    logic [7:0] exp;
    if (ren && a >= TOP)  exp = boot_byte(a);
    else if (off)         exp = 8'h5A;
    else                  exp = model[a];
    rd_en = rd; wr_en = wr; addr = AW'(a); wdata = d;
    rom_en = ren; ram_off = off; ram_wr_ok = wok;
    @(negedge clk);
    if (wr && wok && !off) model[a] = d;
    check({req, " rvalid"}, {31'd0, rvalid}, {31'd0, rd});
    if (rd) check(req, {24'd0, rdata}, {24'd0, exp});
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 rvalid", {31'd0, rvalid}, 32'd0);
    check("R9 rdata", {24'd0, rdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill every location, overlay on (R6 window, R7 register range)
    for (int a = 0; a < DEPTH; a++) op("R6 fill", 0, 1, a, 8'(a * 7 + 3), 1, 0, 1);
    // R4/R6/R7 read back with overlay off
    for (int a = 0; a < DEPTH; a++) begin
      if (a >= TOP)                 op("R6", 1, 0, a, 0, 0, 0, 1);
      else if (a >= 'hF0 && a <= 'hFF) op("R7", 1, 0, a, 0, 0, 0, 1);
      else                          op("R4", 1, 0, a, 0, 0, 0, 1);
    end
    // R2 overlay reads, with and without ram_off
    for (int a = TOP; a < DEPTH; a++) op("R2", 1, 0, a, 0, 1, a[0], 1);
    // R3 blank reads
    for (int a = 0; a < DEPTH; a += 5) op("R3", 1, 0, a, 0, a[1], 1, 1);
    // R5 dropped writes: permit low, or ram off
    for (int a = 0; a < DEPTH; a += 3) op("R5 drop", 0, 1, a, 8'hEE, 1, a[0], a[0]);
    for (int a = 0; a < DEPTH; a += 3) op("R5", 1, 0, a, 0, 0, 0, 1);
    // R7 register range rewrite and readback
    for (int a = 'hF0; a <= 'hFF; a++) op("R7 wr", 0, 1, a, 8'(a ^ 'h3C), 1, 0, 1);
    for (int a = 'hF0; a <= 'hFF; a++) op("R7", 1, 0, a, 0, 1, 0, 1);
    // R8 read-first collision, then the new value
    op("R8", 1, 1, 'h123, 8'h77, 0, 0, 1);
    op("R8 after", 1, 0, 'h123, 0, 0, 0, 1);
    op("R8 win", 1, 1, TOP + 5, 8'h99, 0, 0, 1);
    op("R8 win after", 1, 0, TOP + 5, 0, 0, 0, 1);
    // R1 idle cycle: rvalid low, rdata held
    begin
      logic [7:0] held;
      held = rdata;
      @(negedge clk);
      check("R1 idle rvalid", {31'd0, rvalid}, 32'd0);
      check("R1 idle hold", {24'd0, rdata}, {24'd0, held});
    end
    // Pseudo-random mix against the model (R1..R8)
    for (int n = 0; n < 6000; n++) begin
      int a;
      lfsr = step(lfsr); lfsr = step(lfsr); lfsr = step(lfsr);
      a = lfsr[2] ? int'(lfsr[AW+7:8]) : TOP + int'(lfsr[13:8]);
      op("R4 random", lfsr[0], lfsr[1], a, lfsr[31:24], lfsr[3],
         lfsr[4] & lfsr[5], lfsr[6] | lfsr[7]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule